// File: doc/BRIEF.md
# External Narrow-to-24-bit Word Packer

This block fetches a run of consecutive bytes or halfwords from a slow external memory port and turns them into 24-bit words for writing into internal program memory. A single `start` pulse captures the run configuration: the external start address (the boot stream normally sits at 0x10000), the external width, the number of read wait states (7 is the usual setting) and the number of 24-bit words to produce. The block then reads one external location after another. It holds each address for the programmed number of wait states plus one cycle.

A 24-bit word needs three bytes. In byte mode every group of three reads makes one word. In halfword mode every group of three reads makes two words, and the middle halfword is split across the two. Each finished word comes out with a one-cycle valid strobe and an internal write address that counts up from zero. A one-cycle done pulse marks the last word, and any bytes left over are dropped.

Top module: `ext_word_packer`

## Requirements
- R1: After reset, `busy`, `ext_rd`, `out_valid` and `done` are low and `ext_addr` is zero.
- R2: With `width16` = 0, only `ext_data[7:0]` is used, and three consecutive bytes b0, b1, b2 form the word {b0, b1, b2}, with b0 in bits 23:16.
- R3: With `width16` = 1, three consecutive halfwords h0, h1, h2 form the two words {h0, h1[15:8]} and then {h1[7:0], h2}.
- R4: The first access reads `start_addr`, and each later access reads the previous address plus one.
- R5: Each access keeps `ext_rd` high and `ext_addr` steady for `wait_states`+1 cycles. A run of N words therefore keeps `busy` high for A×(`wait_states`+1) cycles, where A = 3N in byte mode and A = ceil(3N/2) in halfword mode.
- R6: Each emitted word has `out_valid` high for one cycle, and `out_addr` counts 0, 1, 2, … within a run.
- R7: `done` is high for exactly one cycle. For a non-empty run it falls in the same cycle as the last `out_valid`, and `busy` is low from that cycle on.
- R8: A `start` while `busy` is high has no effect. The run continues with its captured configuration.
- R9: A `start` with `word_count` = 0 gives `done` in the next cycle, with no read and no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| width16 | input | 1 | 1 = halfword external data, 0 = byte |
| start_addr | input | ADDR_W | First external address |
| wait_states | input | WS_W | Extra cycles per access |
| word_count | input | CNT_W | Number of 24-bit words to produce |
| ext_addr | output | ADDR_W | External read address |
| ext_rd | output | 1 | External read in progress |
| ext_data | input | 16 | External read data, sampled in the last cycle of an access |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 24 | Packed word |
| out_addr | output | OUT_AW | Internal write address of the word |
| done | output | 1 | Run complete pulse |
| busy | output | 1 | Run in progress |

## Verification
The bench covers several corner cases, each tied to a specific fault it would expose:
- **Halfword split and odd word counts.** In halfword mode it uses odd word counts, where the final halfword is only half used. A packer that mixes up the split byte scrambles every second word, and one that over-reads adds an extra access to the `busy` length.
- **Zero wait states.** Runs with zero wait states catch an off-by-one in the access counter, because the expected cycle count is then exact.
- **Empty run.** A `word_count` of zero checks for a stray read or strobe.
- **Start while busy.** A `start` held high with a different width during a run must leave the output stream unchanged. A design that restarts here would reset `out_addr` and corrupt the data.

// File: rtl/ext_word_packer.sv
module ext_word_packer #(
  parameter int ADDR_W = 24,
  parameter int OUT_AW = 16,
  parameter int CNT_W  = 16,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              width16,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WS_W-1:0]   wait_states,
  input  logic [CNT_W-1:0]  word_count,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  input  logic [15:0]       ext_data,
  output logic              out_valid,
  output logic [23:0]       out_data,
  output logic [OUT_AW-1:0] out_addr,
  output logic              done,
  output logic              busy
);

  logic [WS_W-1:0]   wcnt, ws_q;
  logic              w16_q;
  logic [CNT_W-1:0]  left;
  logic [OUT_AW-1:0] wr_idx;
  logic [15:0]       held;
  logic [1:0]        nheld;

  logic        acc_done, emit;
  logic [23:0] word;
  logic [15:0] held_nx;
  logic [1:0]  nheld_nx;

  assign ext_rd   = busy;
  assign acc_done = busy && (wcnt == '0);

  always_comb begin
    emit     = 1'b0;
    word     = {held, ext_data[15:8]};
    held_nx  = held;
    nheld_nx = nheld;
    if (!w16_q) begin
      word    = {held, ext_data[7:0]};
      held_nx = {held[7:0], ext_data[7:0]};
      if (nheld == 2'd2) begin
        emit     = 1'b1;
        nheld_nx = 2'd0;
      end else begin
        nheld_nx = nheld + 2'd1;
      end
    end else begin
      case (nheld)
        2'd0: begin
          held_nx  = ext_data;
          nheld_nx = 2'd2;
        end
        2'd2: begin
          emit     = 1'b1;
          word     = {held, ext_data[15:8]};
          held_nx  = {8'h00, ext_data[7:0]};
          nheld_nx = 2'd1;
        end
        default: begin
          emit     = 1'b1;
          word     = {held[7:0], ext_data};
          nheld_nx = 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ext_addr  <= '0;
      wcnt      <= '0;
      ws_q      <= '0;
      w16_q     <= 1'b0;
      left      <= '0;
      wr_idx    <= '0;
      held      <= '0;
      nheld     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (word_count == '0) begin
            done <= 1'b1;
          end else begin
            busy     <= 1'b1;
            ext_addr <= start_addr;
            wcnt     <= wait_states;
            ws_q     <= wait_states;
            w16_q    <= width16;
            left     <= word_count;
            wr_idx   <= '0;
            nheld    <= '0;
          end
        end
      end else if (!acc_done) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        ext_addr <= ext_addr + 1'b1;
        wcnt     <= ws_q;
        held     <= held_nx;
        nheld    <= nheld_nx;
        if (emit) begin
          out_valid <= 1'b1;
          out_data  <= word;
          out_addr  <= wr_idx;
          wr_idx    <= wr_idx + 1'b1;
          left      <= left - 1'b1;
          if (left == 1) begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
      end
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(ext_addr)) |-> ext_addr == $past(ext_addr) + 1'b1);
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(wcnt) != '0) |-> $stable(ext_addr));
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(w16_q) && $stable(ws_q)));
  a_r6_valid_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> !busy);

endmodule

// File: tb/ext_word_packer_tb_top.sv
module ext_word_packer_tb_top;
  logic clk = 0, rst_n = 0, start = 0, width16 = 0;
  logic [23:0] start_addr = 0;
  logic [3:0]  wait_states = 0;
  logic [15:0] word_count = 0;
  logic [23:0] ext_addr;
  logic ext_rd, out_valid, done, busy;
  logic [15:0] ext_data;
  logic [23:0] out_data;
  logic [15:0] out_addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem(input logic [23:0] a);
    logic [31:0] x;
    x = a * 32'h9E37 + (a >> 5) + 32'h5A;
    return x[15:0];
  endfunction

  assign ext_data = mem(ext_addr);

  ext_word_packer dut_i (.clk, .rst_n, .start, .width16, .start_addr, .wait_states,
    .word_count, .ext_addr, .ext_rd, .ext_data, .out_valid, .out_data, .out_addr,
    .done, .busy);

  function automatic logic [7:0] stream_byte(input logic w16, input logic [23:0] sa, input int j);
    logic [15:0] h;
    if (!w16) begin
      h = mem(sa + j);
      return h[7:0];
    end
    h = mem(sa + j / 2);
    return (j % 2 == 0) ? h[15:8] : h[7:0];
  endfunction

  function automatic logic [23:0] exp_word(input logic w16, input logic [23:0] sa, input int k);
    return {stream_byte(w16, sa, 3*k), stream_byte(w16, sa, 3*k+1), stream_byte(w16, sa, 3*k+2)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic w16, input logic [23:0] sa, input logic [3:0] ws,
                     input int n, input bit poke);
    int nv, bcyc, acc, cyc, ndone;
    logic [23:0] prev;
    bit first;
    nv = 0; bcyc = 0; cyc = 0; ndone = 0; first = 1; prev = 0;
    acc = w16 ? (3*n + 1) / 2 : 3*n;
    @(negedge clk);
    width16 = w16; start_addr = sa; wait_states = ws; word_count = n[15:0]; start = 1;
    @(negedge clk);
    start = 0;
    if (n == 0) begin
      chk(done && !busy && !out_valid, "R9", {done, busy, out_valid}, 3'b100);
      @(negedge clk);
      chk(!done && !busy && !ext_rd, "R9", {done, busy, ext_rd}, 0);
      return;
    end
    forever begin
      if (poke && cyc < 3) begin
        start = 1; width16 = !w16; wait_states = 0; start_addr = 24'h0;
      end else start = 0;
      if (busy) begin
        bcyc++;
        if (first) chk(ext_addr == sa, "R4", ext_addr, sa);
        else if (ext_addr != prev) chk(ext_addr == prev + 1, "R4", ext_addr, prev + 1);
        first = 0; prev = ext_addr;
      end
      if (out_valid) begin
        chk(out_data == exp_word(w16, sa, nv), w16 ? "R3" : "R2", out_data, exp_word(w16, sa, nv));
        chk(out_addr == nv[15:0], "R6", out_addr, nv);
        nv++;
      end
      if (done) begin
        ndone++;
        chk(out_valid && !busy, "R7", {out_valid, busy}, 2'b10);
        break;
      end
      cyc++;
      if (cyc > 20000) begin
        chk(0, "R7 timeout", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    start = 0;
    chk(nv == n, poke ? "R8" : "R6", nv, n);
    chk(bcyc == acc * (ws + 1), "R5", bcyc, acc * (ws + 1));
    @(negedge clk);
    chk(!done && !busy, "R7", {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !ext_rd && !out_valid && !done && ext_addr == 0, "R1",
        {busy, ext_rd, out_valid, done}, 0);
    rst_n = 1;
    run(0, 24'h010000, 4'd7, 4, 0);
    run(1, 24'h010000, 4'd0, 5, 0);
    run(1, 24'h000100, 4'd2, 1, 0);
    run(0, 24'h000100, 4'd0, 1, 0);
    run(0, 24'h000000, 4'd3, 0, 0);
    run(1, 24'h000000, 4'd0, 0, 0);
    run(0, 24'h020000, 4'd3, 4, 1);
    run(1, 24'h0000F0, 4'd3, 3, 1);
    for (int i = 0; i < 12; i++)
      run(1'($urandom_range(0, 1)), 24'($urandom), 4'($urandom_range(0, 15)),
          int'($urandom_range(1, 9)), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule